// File: doc/BRIEF.md
# Decode-stage instruction pair fusion detector

The block looks at a decode bundle of `SLOTS` consecutive 32-bit instruction words, each with a valid bit. It searches every neighbouring pair of slots for shift, mask and add sequences that a single internal micro-op can carry out. When a pair matches, the earlier slot is tagged as fused and carries the op code of the merged operation. The later slot drops out of the bundle, and the earlier slot records how far away the dropped partner sat, so that a downstream fetch-target tracker can still count it as retired.

Detection works on raw instruction fields only: opcode, funct3, funct7, immediate, shift amount and register numbers. There are two rules on top of the pattern match. The second instruction must consume the first one's result and overwrite that same register. A slot that has already been absorbed as a second half cannot open a new pair. Pairs are resolved from slot 0 upward. All outputs are registered, so results appear one clock after the bundle is presented.

Top module: `pair_fuse_detect`

## Requirements
- R1: While `rst_n` is low, all outputs are zero.
- R2: Outputs describe the bundle presented on the previous rising clock edge, so the latency is exactly one cycle.
- R3: A slot that is neither fused nor absorbed copies its input valid bit. A slot whose input valid is 0 is never valid, fused or part of a pair.
- R4: Shift and mask pairs, written first;second with the 4-bit op code: slli 32;srli 31 gives 1. slli 32;srli 30 gives 2. srli 8;andi 255 gives 3. slli 48;srai 48 gives 14. slli 48;srli 48 gives 15. Shifts use opcode 0010011, funct3 001 (left) or 101 (right), and imm[11:6] is 000000, or 010000 for srai.
- R5: Shift and add pairs, where the second instruction is add (opcode 0110011, funct3 000, funct7 0): slli 4 gives 4. srli 30, 31 or 32 gives 5, 6 or 7. slli 1, 2 or 3 gives 11, 12 or 13.
- R6: Mask pairs, with andi being opcode 0010011 and funct3 111: andi 1;add gives 8. andi 1;addw (opcode 0111011, funct3 000, funct7 0) gives 9. andi -256;or (opcode 0110011, funct3 110, funct7 0) gives 10.
- R7: A pair fuses only if all of these hold: the first rd (bits 11:7) is not x0; the second instruction's rd and rs1 (bits 19:15) equal that rd; and, when the second instruction is register-register, its rs2 (bits 24:20) differs from that rd.
- R8: For a fused pair at slots i and i+1, `out_fused[i]` is 1, `out_valid[i]` stays 1, `out_valid[i+1]` is 0, and the op code appears in `out_op[4i+3:4i]`. Op code 0 means not fused.
- R9: `out_off[2i+1:2i]` gives the distance to the removed partner in 16-bit units minus one. It is 1 on every fused slot, because both halves are 32-bit, and 0 on every other slot.
- R10: Matching runs from slot 0 upward. A slot absorbed as a second half never starts a pair, and the last slot is never fused.
- R11: If either instruction of a pair has bits 1:0 not equal to 11 (a compressed instruction), that pair does not fuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | SLOTS | Per-slot valid of the incoming bundle |
| in_instr | input | 32*SLOTS | Instruction words, slot i in bits 32i+31:32i |
| out_valid | output | SLOTS | Per-slot valid after absorption of second halves |
| out_fused | output | SLOTS | Slot heads a fused pair |
| out_op | output | 4*SLOTS | Fused op code per slot, 0 when not fused |
| out_off | output | 2*SLOTS | Partner distance code per slot |

## Verification
The bench targets overlapping candidates. Three instructions in a row can each pair with their neighbour, so a design that does not apply the lowest-first rule would either fuse the middle instruction twice or drop a valid slot. It also feeds pairs that break the register rule in the ways that matter: rd equal to x0, the second instruction writing a different register, or the add reading the intermediate through rs2. A loose dependency check would merge all of these into ops that compute the wrong value. Compressed words, invalid slots and the last slot are exercised too. A design that ignored any of them would fuse across a hole in the bundle or past its end.

// File: rtl/pair_fuse_detect.sv
module pair_fuse_detect #(
  parameter int SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SLOTS-1:0]     in_valid,
  input  logic [SLOTS*32-1:0]  in_instr,
  output logic [SLOTS-1:0]     out_valid,
  output logic [SLOTS-1:0]     out_fused,
  output logic [SLOTS*4-1:0]   out_op,
  output logic [SLOTS*2-1:0]   out_off
);

  localparam logic [3:0] OP_NONE    = 4'd0;
  localparam logic [3:0] OP_SZEWL1  = 4'd1;
  localparam logic [3:0] OP_SZEWL2  = 4'd2;
  localparam logic [3:0] OP_BYTE2   = 4'd3;
  localparam logic [3:0] OP_SH4ADD  = 4'd4;
  localparam logic [3:0] OP_SR30ADD = 4'd5;
  localparam logic [3:0] OP_SR31ADD = 4'd6;
  localparam logic [3:0] OP_SR32ADD = 4'd7;
  localparam logic [3:0] OP_ODDADD  = 4'd8;
  localparam logic [3:0] OP_ODDADDW = 4'd9;
  localparam logic [3:0] OP_ORH48   = 4'd10;
  localparam logic [3:0] OP_SH1ADD  = 4'd11;
  localparam logic [3:0] OP_SH2ADD  = 4'd12;
  localparam logic [3:0] OP_SH3ADD  = 4'd13;
  localparam logic [3:0] OP_SEXTH   = 4'd14;
  localparam logic [3:0] OP_ZEXTH   = 4'd15;
  localparam logic [1:0] OFF_WORD   = 2'd1;

  function automatic logic [3:0] pair_op(input logic [31:0] a, input logic [31:0] b);
    logic [4:0]  rd;
    logic [5:0]  sa, sb;
    logic        a_sll, a_srl, a_and, b_srl, b_sra, b_and, b_add, b_or, b_addw;
    logic        ok, rok;
    logic [3:0]  r;
    rd    = a[11:7];
    sa    = a[25:20];
    sb    = b[25:20];
    a_sll = a[6:0] == 7'h13 && a[14:12] == 3'b001 && a[31:26] == 6'd0;
    a_srl = a[6:0] == 7'h13 && a[14:12] == 3'b101 && a[31:26] == 6'd0;
    a_and = a[6:0] == 7'h13 && a[14:12] == 3'b111;
    b_srl = b[6:0] == 7'h13 && b[14:12] == 3'b101 && b[31:26] == 6'd0;
    b_sra = b[6:0] == 7'h13 && b[14:12] == 3'b101 && b[31:26] == 6'b010000;
    b_and = b[6:0] == 7'h13 && b[14:12] == 3'b111;
    b_add = b[6:0] == 7'h33 && b[14:12] == 3'b000 && b[31:25] == 7'd0;
    b_or  = b[6:0] == 7'h33 && b[14:12] == 3'b110 && b[31:25] == 7'd0;
    b_addw = b[6:0] == 7'h3b && b[14:12] == 3'b000 && b[31:25] == 7'd0;
    ok  = a[1:0] == 2'b11 && b[1:0] == 2'b11 && rd != 5'd0 &&
          b[11:7] == rd && b[19:15] == rd;
    rok = ok && b[24:20] != rd;
    r = OP_NONE;
    if (ok && a_sll && sa == 6'd32 && b_srl && sb == 6'd31)       r = OP_SZEWL1;
    else if (ok && a_sll && sa == 6'd32 && b_srl && sb == 6'd30)  r = OP_SZEWL2;
    else if (ok && a_srl && sa == 6'd8 && b_and && b[31:20] == 12'd255) r = OP_BYTE2;
    else if (ok && a_sll && sa == 6'd48 && b_sra && sb == 6'd48)  r = OP_SEXTH;
    else if (ok && a_sll && sa == 6'd48 && b_srl && sb == 6'd48)  r = OP_ZEXTH;
    else if (rok && a_sll && b_add && sa == 6'd4)                 r = OP_SH4ADD;
    else if (rok && a_sll && b_add && sa == 6'd1)                 r = OP_SH1ADD;
    else if (rok && a_sll && b_add && sa == 6'd2)                 r = OP_SH2ADD;
    else if (rok && a_sll && b_add && sa == 6'd3)                 r = OP_SH3ADD;
    else if (rok && a_srl && b_add && sa == 6'd30)                r = OP_SR30ADD;
    else if (rok && a_srl && b_add && sa == 6'd31)                r = OP_SR31ADD;
    else if (rok && a_srl && b_add && sa == 6'd32)                r = OP_SR32ADD;
    else if (rok && a_and && a[31:20] == 12'd1 && b_add)          r = OP_ODDADD;
    else if (rok && a_and && a[31:20] == 12'd1 && b_addw)         r = OP_ODDADDW;
    else if (rok && a_and && a[31:20] == 12'hf00 && b_or)         r = OP_ORH48;
    return r;
  endfunction

  logic [SLOTS-1:0][3:0] cand;
  logic [SLOTS-1:0]      take;
  logic [SLOTS:0]        eaten;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cand
    if (i < SLOTS - 1) begin : g_pair
      assign cand[i] = (in_valid[i] && in_valid[i+1]) ?
                       pair_op(in_instr[i*32 +: 32], in_instr[(i+1)*32 +: 32]) : OP_NONE;
    end else begin : g_last
      assign cand[i] = OP_NONE;
    end
  end

  always_comb begin
    eaten = '0;
    for (int i = 0; i < SLOTS; i++) begin
      take[i]      = (cand[i] != OP_NONE) && !eaten[i];
      eaten[i+1]   = take[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_fused <= '0;
      out_op    <= '0;
      out_off   <= '0;
    end else begin
      out_valid <= in_valid & ~eaten[SLOTS-1:0];
      out_fused <= take;
      for (int i = 0; i < SLOTS; i++) begin
        out_op[i*4 +: 4]  <= take[i] ? cand[i] : OP_NONE;
        out_off[i*2 +: 2] <= take[i] ? OFF_WORD : 2'd0;
      end
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_chk
    // R3
    dead_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[i] |=> !out_valid[i] && !out_fused[i]);
    // R8
    head_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_fused[i] |-> out_valid[i]);
    // R8
    op_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_op[i*4 +: 4] != OP_NONE) == out_fused[i]);
    // R9
    off_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_off[i*2 +: 2] == (out_fused[i] ? OFF_WORD : 2'd0));
    if (i < SLOTS - 1) begin : g_nb
      // R10
      tail_absorbed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_fused[i] |-> !out_valid[i+1] && !out_fused[i+1]);
      // R11
      short_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_instr[i*32 +: 2] != 2'b11 || in_instr[(i+1)*32 +: 2] != 2'b11) |=> !out_fused[i]);
    end else begin : g_end
      // R10
      last_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_fused[i]);
    end
  end

endmodule

// File: tb/test_pair_fuse_detect.sv
module test_pair_fuse_detect;
  localparam int N = 4;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [N-1:0]    in_valid = '0;
  logic [N*32-1:0] in_instr = '0;
  logic [N-1:0]    out_valid, out_fused;
  logic [N*4-1:0]  out_op;
  logic [N*2-1:0]  out_off;

  int checks = 0;
  int errors = 0;

  int exp_v[N], exp_f[N], exp_o[N], exp_d[N];
  bit have_exp = 0;
  string exp_tag = "R2";

  always #5 clk = ~clk;

  pair_fuse_detect #(.SLOTS(N)) i_pair_fuse_detect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .out_valid(out_valid), .out_fused(out_fused), .out_op(out_op), .out_off(out_off));

  function automatic logic [31:0] imm_w(int f3, int rd, int rs1, int imm);
    return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), 7'h13};
  endfunction
  function automatic logic [31:0] reg_w(logic [6:0] opc, int f3, int rd, int rs1, int rs2);
    return {7'd0, 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), opc};
  endfunction
  function automatic logic [31:0] slli(int rd, int rs, int s); return imm_w(1, rd, rs, s); endfunction
  function automatic logic [31:0] srli(int rd, int rs, int s); return imm_w(5, rd, rs, s); endfunction
  function automatic logic [31:0] srai(int rd, int rs, int s); return imm_w(5, rd, rs, 'h400 + s); endfunction
  function automatic logic [31:0] andi(int rd, int rs, int m); return imm_w(7, rd, rs, m); endfunction
  function automatic logic [31:0] add (int rd, int a, int b); return reg_w(7'h33, 0, rd, a, b); endfunction
  function automatic logic [31:0] orr (int rd, int a, int b); return reg_w(7'h33, 6, rd, a, b); endfunction
  function automatic logic [31:0] addw(int rd, int a, int b); return reg_w(7'h3b, 0, rd, a, b); endfunction

  // kinds: 1 slli 2 srli 3 srai 4 andi 5 add 6 addw 7 or, 0 anything else
  function automatic void decode(input logic [31:0] w, output int k, output int arg);
    k = 0; arg = 0;
    if (w[6:0] == 7'h13) begin
      if (w[14:12] == 3'd1 && w[31:26] == 6'd0) begin k = 1; arg = int'(w[25:20]); end
      else if (w[14:12] == 3'd5 && w[31:26] == 6'd0) begin k = 2; arg = int'(w[25:20]); end
      else if (w[14:12] == 3'd5 && w[31:26] == 6'b010000) begin k = 3; arg = int'(w[25:20]); end
      else if (w[14:12] == 3'd7) begin k = 4; arg = int'($signed(w[31:20])); end
    end else if (w[31:25] == 7'd0) begin
      if (w[6:0] == 7'h33 && w[14:12] == 3'd0) k = 5;
      else if (w[6:0] == 7'h3b && w[14:12] == 3'd0) k = 6;
      else if (w[6:0] == 7'h33 && w[14:12] == 3'd6) k = 7;
    end
  endfunction

  function automatic int model_op(logic [31:0] a, logic [31:0] b);
    int ka, aa, kb, ab, rd;
    if (a[1:0] != 2'b11 || b[1:0] != 2'b11) return 0;      // R11
    decode(a, ka, aa);
    decode(b, kb, ab);
    rd = int'(a[11:7]);
    if (rd == 0 || int'(b[11:7]) != rd || int'(b[19:15]) != rd) return 0;  // R7
    if (kb >= 5 && int'(b[24:20]) == rd) return 0;
    if (ka == 1 && aa == 32 && kb == 2 && ab == 31) return 1;
    if (ka == 1 && aa == 32 && kb == 2 && ab == 30) return 2;
    if (ka == 2 && aa == 8 && kb == 4 && ab == 255) return 3;
    if (ka == 1 && aa == 48 && kb == 3 && ab == 48) return 14;
    if (ka == 1 && aa == 48 && kb == 2 && ab == 48) return 15;
    if (ka == 1 && kb == 5) begin
      if (aa == 4) return 4;
      if (aa >= 1 && aa <= 3) return 10 + aa;
    end
    if (ka == 2 && kb == 5 && aa >= 30 && aa <= 32) return aa - 25;
    if (ka == 4 && aa == 1 && kb == 5) return 8;
    if (ka == 4 && aa == 1 && kb == 6) return 9;
    if (ka == 4 && aa == -256 && kb == 7) return 10;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int slot, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s slot %0d actual %0d expected %0d", tag, what, slot, act, exp);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < N; i++) begin
      chk(exp_v[i] == 0 && exp_f[i] == 0 && i > 0 && exp_f[i-1] == 1 ? "R8" : "R3",
          "valid", i, int'(out_valid[i]), exp_v[i]);
      chk(exp_tag, "fused", i, int'(out_fused[i]), exp_f[i]);
      chk(exp_tag, "op", i, int'(out_op[i*4 +: 4]), exp_o[i]);
      chk("R9", "off", i, int'(out_off[i*2 +: 2]), exp_d[i]);
    end
  endtask

  // drive at a falling edge, check the registered result at the next falling edge (R2)
  task automatic step(logic [N-1:0] v, logic [N*32-1:0] w, string tag);
    bit used;
    if (have_exp) compare();
    in_valid = v;
    in_instr = w;
    used = 0;
    for (int i = 0; i < N; i++) begin
      int o;
      o = 0;
      if (!used && i + 1 < N && v[i] && v[i+1]) o = model_op(w[i*32 +: 32], w[(i+1)*32 +: 32]);
      exp_f[i] = (o != 0);
      exp_o[i] = o;
      exp_d[i] = (o != 0) ? 1 : 0;
      exp_v[i] = (v[i] && !used) ? 1 : 0;
      used = (o != 0);
    end
    exp_tag = tag;
    have_exp = 1;
    @(negedge clk);
  endtask

  function automatic logic [N*32-1:0] pack(logic [31:0] a, logic [31:0] b,
                                           logic [31:0] c, logic [31:0] d);
    return {d, c, b, a};
  endfunction

  localparam logic [31:0] NOP = 32'h0000_0013;

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    in_valid = '1;
    in_instr = pack(slli(1,2,32), srli(1,1,31), NOP, NOP);
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "valid", 0, int'(out_valid), 0);
    chk("R1", "fused", 0, int'(out_fused), 0);
    chk("R1", "op",    0, int'(out_op),    0);
    chk("R1", "off",   0, int'(out_off),   0);
    rst_n = 1;
    // R4
    step('1, pack(slli(1,2,32), srli(1,1,31), slli(3,4,32), srli(3,3,30)), "R4");
    step('1, pack(srli(5,6,8), andi(5,5,255), slli(7,8,48), srai(7,7,48)), "R4");
    step('1, pack(NOP, slli(9,2,48), srli(9,9,48), NOP), "R4");
    // R5
    step('1, pack(slli(1,2,4), add(1,1,3), srli(4,5,30), add(4,4,6)), "R5");
    step('1, pack(srli(1,2,31), add(1,1,3), srli(4,5,32), add(4,4,6)), "R5");
    step('1, pack(slli(1,2,1), add(1,1,3), slli(4,5,2), add(4,4,6)), "R5");
    step('1, pack(NOP, slli(8,2,3), add(8,8,9), NOP), "R5");
    // R6
    step('1, pack(andi(1,2,1), add(1,1,3), andi(4,5,1), addw(4,4,6)), "R6");
    step('1, pack(andi(1,2,-256), orr(1,1,3), NOP, NOP), "R6");
    // R7: rd x0, wrong destination, wrong source, add reading intermediate via rs2
    step('1, pack(slli(0,2,4), add(0,0,3), slli(1,2,4), add(2,1,3)), "R7");
    step('1, pack(slli(1,2,4), add(1,3,1), slli(1,2,4), add(1,1,1)), "R7");
    step('1, pack(andi(4,2,2), add(4,4,3), srli(5,2,9), andi(5,5,255)), "R7");
    // R10: chain of three candidates, last slot alone
    step('1, pack(slli(1,2,32), srli(1,1,31), add(1,1,3), NOP), "R10");
    step('1, pack(slli(1,2,32), srli(1,1,30), srli(1,1,30), add(1,1,3)), "R10");
    step('1, pack(NOP, NOP, NOP, slli(1,2,4)), "R10");
    // R11: compressed words
    step('1, pack(slli(1,2,4) & ~32'h3, add(1,1,3), slli(4,2,4), add(4,4,3) & ~32'h1), "R11");
    // R3: invalid slots break pairs
    step(4'b1101, pack(slli(1,2,4), add(1,1,3), andi(4,5,1), add(4,4,6)), "R3");
    step(4'b0110, pack(slli(1,2,4), add(1,1,3), andi(4,5,1), add(4,4,6)), "R3");
    step(4'b0000, pack(slli(1,2,4), add(1,1,3), andi(4,5,1), add(4,4,6)), "R3");
    // random bundles built from matching pieces (R7 dependency rule dominates)
    for (int n = 0; n < 400; n++) begin
      logic [N*32-1:0] w;
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) begin
        int rd, rs, sel;
        logic [31:0] x;
        rd  = $urandom_range(0, 3);
        rs  = $urandom_range(1, 4);
        sel = $urandom_range(0, 14);
        case (sel)
          0: x = slli(rd, rs, 32);
          1: x = slli(rd, rs, $urandom_range(1, 4));
          2: x = slli(rd, rs, 48);
          3: x = srli(rd, rs, $urandom_range(30, 32));
          4: x = srli(rd, rs, 8);
          5: x = andi(rd, rs, ($urandom_range(0, 1) != 0) ? 1 : -256);
          6: x = srli(rd, rd, ($urandom_range(0, 1) != 0) ? 31 : 48);
          7: x = srai(rd, rd, 48);
          8: x = andi(rd, rd, 255);
          9: x = add(rd, rd, rs);
          10: x = addw(rd, rd, rs);
          11: x = orr(rd, rd, rs);
          12: x = add(rd, rs, rd);
          13: x = $urandom;
          default: x = srli(rd, rd, 30);
        endcase
        if ($urandom_range(0, 19) == 0) x[1:0] = 2'b01;
        w[i*32 +: 32] = x;
        v[i] = ($urandom_range(0, 9) != 0);
      end
      step(v, w, "R7");
    end
    step('0, '0, "R2");
    compare();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule